// File: doc/BRIEF.md
# Interlocked Asynchronous Bus Read Master

This block issues memory read cycles on a bus with no shared clock. The two sides pace each other through a four-phase interlock. A local client presents an address and pulses `start`. The master then puts the address on the bus and raises the memory-request and read strobes. After a short setup time it raises master-sync. It waits for the slave to answer with slave-sync, captures the data lines at that point, and withdraws every strobe. The cycle only counts as finished once the slave has dropped slave-sync in its turn. A slow slave simply holds the master in its wait state longer.

The master runs in its own synchronous clock domain. Slave-sync reaches the control logic only through a multi-flop synchronizer. A programmable limit bounds how long the master waits for the acknowledge. When no answer comes in time, the master abandons the read, drops its strobes, and reports a timeout together with the completion pulse. Write cycles, arbitration and tri-state drive are handled elsewhere.

Top module: `hs_read_master`

## Requirements
- R1: After reset, `busAddr` is zero, and `busMreq`, `busRd`, `busMsyn`, `busy`, `done`, `timeout` and `rdata` are all low or zero.
- R2: A `start` sampled while idle makes `busy` high one clock later. Two clocks later, `busAddr` carries the sampled `addr` and `busMreq` and `busRd` are high.
- R3: `busMsyn` rises exactly SETUP_CYC clocks after `busMreq` rises. `busAddr`, `busMreq` and `busRd` stay unchanged while `busMsyn` is high.
- R4: The master treats data as valid only after it sees the synchronized slave-sync. It latches `busData` on that edge, and `rdata` holds that value when `done` pulses.
- R5: Once the acknowledge is taken, `busMreq`, `busRd` and `busMsyn` are all negated, and `busAddr` returns to zero, before `done` pulses.
- R6: `busy` stays high and `done` stays low as long as `busSsyn` is still asserted after master-sync has dropped. `done` is a single-clock pulse and coincides with `busy` going low.
- R7: A `start` pulse while `busy` is high has no effect: the bus address does not change and no extra cycle or `done` pulse follows.
- R8: Any slave response delay well inside the limit completes normally, with no change to control settings.
- R9: With no slave response, `busMsyn` stays high for exactly `tmoLimit` clocks. All strobes are then negated, `done` pulses with `timeout` high, and `rdata` keeps its previous value.
- R10: The acknowledge wins when it lands on the same edge as the limit expiry. With the default two-flop synchronizer, slave-sync raised half a clock plus d clocks after master-sync rises completes normally for d = `tmoLimit`-4 and times out for d = `tmoLimit`-3.
- R11: `timeout` stays high after an aborted cycle and clears on the clock edge that accepts the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a read cycle (sampled when idle) |
| addr | input | ADDR_W | Read address for the request |
| tmoLimit | input | TMO_W | Clocks allowed for the acknowledge (at least 5) |
| busy | output | 1 | A read cycle is in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DATA_W | Data captured from the last successful read |
| timeout | output | 1 | Last cycle was aborted for lack of acknowledge |
| busAddr | output | ADDR_W | Address lines to the bus, zero when idle |
| busMreq | output | 1 | Memory-request strobe |
| busRd | output | 1 | Read strobe |
| busMsyn | output | 1 | Master-sync strobe |
| busData | input | DATA_W | Data lines from the slave |
| busSsyn | input | 1 | Slave-sync acknowledge (asynchronous) |

## Verification
The acknowledge and the timeout expiry can fall on the same clock edge. The synchronized slave-sync becomes visible just as the wait counter reaches `tmoLimit`-1. The bench provokes this with its reactive slave model, which places the slave-sync rise one clock either side of the expiry edge. For the collision case, it requires fresh `rdata` and a low `timeout`. For the case one clock later, it requires an abort with `rdata` unchanged. In both cases it also measures the master-sync width at the bus pins, which must be exactly `tmoLimit` clocks.

// File: rtl/hs_read_pkg.sv
package hs_read_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SYNC,
    ST_RELEASE,
    ST_ABORT
  } hsState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;   // take a new request address
    logic driveReq;   // address, memory-request and read on the bus
    logic driveSync;  // master-sync on the bus
    logic capture;    // latch the data lines
    logic clrCnt;     // restart the phase counter
    logic finish;     // raise the completion pulse
    logic abort;      // record a timeout
  } hsCmd_t;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/hs_read_dpath.sv
module hs_read_dpath
  import hs_read_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  hsCmd_t            cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] busData,
  input  logic              busSsyn,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busMreq,
  output logic              busRd,
  output logic              busMsyn,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              timeout,
  output logic              ssynSync,
  output logic [CNT_W-1:0]  phaseCnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [ADDR_W-1:0] addrReg;

  hs_sync #(.STAGES(SYNC_STAGES)) ssynSyncI (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (busSsyn),
    .syncOut (ssynSync)
  );

  // request address and bus drivers, all registered
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      busAddr <= '0;
      busMreq <= 1'b0;
      busRd   <= 1'b0;
      busMsyn <= 1'b0;
    end else begin
      if (cmd.loadAddr) addrReg <= addr;
      busAddr <= cmd.driveReq ? addrReg : '0;
      busMreq <= cmd.driveReq;
      busRd   <= cmd.driveReq;
      busMsyn <= cmd.driveSync;
    end
  end

  // read data and result flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata   <= '0;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      if (cmd.capture) rdata <= busData;
      done <= cmd.finish;
      if (cmd.abort)         timeout <= 1'b1;
      else if (cmd.loadAddr) timeout <= 1'b0;
    end
  end

  // shared setup / wait counter, saturating
  always_ff @(posedge clk) begin
    if (!rstN)                    phaseCnt <= '0;
    else if (cmd.clrCnt)          phaseCnt <= '0;
    else if (phaseCnt != CNT_MAX) phaseCnt <= phaseCnt + 1'b1;
  end

endmodule

// File: rtl/hs_read_ctrl.sv
module hs_read_ctrl
  import hs_read_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int SETUP_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             ssynSync,
  input  logic [CNT_W-1:0] phaseCnt,
  input  logic [CNT_W-1:0] tmoLimit,
  output hsCmd_t           cmd,
  output logic             busy
);

  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

  hsState_t state, stateNext;
  logic     limitHit;

  assign limitHit = (phaseCnt == (tmoLimit - CNT_ONE));

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    cmd       = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          cmd.loadAddr = 1'b1;
          cmd.clrCnt   = 1'b1;
          stateNext    = ST_SETUP;
        end
      end
      ST_SETUP: begin
        cmd.driveReq = 1'b1;
        if (phaseCnt == SETUP_LAST) begin
          cmd.clrCnt = 1'b1;
          stateNext  = ST_SYNC;
        end
      end
      ST_SYNC: begin
        cmd.driveReq  = 1'b1;
        cmd.driveSync = 1'b1;
        if (ssynSync) begin
          cmd.capture = 1'b1;   // acknowledge has priority over the limit
          stateNext   = ST_RELEASE;
        end else if (limitHit) begin
          cmd.abort = 1'b1;
          stateNext = ST_ABORT;
        end
      end
      ST_RELEASE, ST_ABORT: begin
        if (!ssynSync) begin
          cmd.finish = 1'b1;
          stateNext  = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/hs_read_master.sv
module hs_read_master
  import hs_read_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int TMO_W       = 12,
  parameter int SETUP_CYC   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TMO_W-1:0]  tmoLimit,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              timeout,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busMreq,
  output logic              busRd,
  output logic              busMsyn,
  input  logic [DATA_W-1:0] busData,
  input  logic              busSsyn
);

  hsCmd_t           cmd;
  logic             ssynSync;
  logic [TMO_W-1:0] phaseCnt;

  hs_read_ctrl #(
    .CNT_W     (TMO_W),
    .SETUP_CYC (SETUP_CYC)
  ) ctrlI (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .ssynSync (ssynSync),
    .phaseCnt (phaseCnt),
    .tmoLimit (tmoLimit),
    .cmd      (cmd),
    .busy     (busy)
  );

  hs_read_dpath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .CNT_W       (TMO_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) dpathI (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .addr     (addr),
    .busData  (busData),
    .busSsyn  (busSsyn),
    .busAddr  (busAddr),
    .busMreq  (busMreq),
    .busRd    (busRd),
    .busMsyn  (busMsyn),
    .rdata    (rdata),
    .done     (done),
    .timeout  (timeout),
    .ssynSync (ssynSync),
    .phaseCnt (phaseCnt)
  );

endmodule

// File: rtl/hs_read_master_chk.sv
module hs_read_master_chk #(
  parameter int ADDR_W    = 16,
  parameter int SETUP_CYC = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busMreq,
  input logic              busRd,
  input logic              busMsyn,
  input logic              busSsyn
);

  localparam int RC_W = $clog2(SETUP_CYC + 2) + 1;
  localparam logic [RC_W-1:0] RC_MAX   = '1;
  localparam logic [RC_W-1:0] RC_SETUP = RC_W'(SETUP_CYC);

  logic [RC_W-1:0] reqCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                reqCnt <= '0;
    else if (!busMreq)        reqCnt <= '0;
    else if (reqCnt != RC_MAX) reqCnt <= reqCnt + 1'b1;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!busMreq && !busRd && !busMsyn && busAddr == '0));

  // R3
  setup_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busMsyn) |-> (reqCnt == RC_SETUP));

  // R3
  sync_under_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    busMsyn |-> (busMreq && busRd));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busMsyn && $past(busMsyn)) |-> $stable(busAddr));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busMsyn && !busMreq && !busy));

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busMreq) |-> !busSsyn);

endmodule

bind hs_read_master hs_read_master_chk #(
  .ADDR_W    (ADDR_W),
  .SETUP_CYC (SETUP_CYC)
) chkI (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .done    (done),
  .busAddr (busAddr),
  .busMreq (busMreq),
  .busRd   (busRd),
  .busMsyn (busMsyn),
  .busSsyn (busSsyn)
);

// File: tb/tb_hs_read_master.sv
`timescale 1ns/1ps
module tb_hs_read_master;

  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 16;
  localparam int TMO_W     = 12;
  localparam int SETUP_CYC = 2;
  localparam logic [15:0] MAGIC = 16'hA5A5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [TMO_W-1:0]  tmoLimit = 12'd200;
  logic              busy, done, timeout;
  logic [DATA_W-1:0] rdata;
  logic [ADDR_W-1:0] busAddr;
  logic              busMreq, busRd, busMsyn;
  logic [DATA_W-1:0] busData = '0;
  logic              busSsyn = 1'b0;

  int total = 0;
  int bad = 0;
  int slaveDelay = 2;
  int relDelay = 3;
  bit slaveMute = 1'b0;
  bit finished = 1'b0;

  hs_read_master #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMO_W(TMO_W), .SETUP_CYC(SETUP_CYC)
  ) dut (
    .clk(clk), .rstN(rstN), .start(start), .addr(addr), .tmoLimit(tmoLimit),
    .busy(busy), .done(done), .rdata(rdata), .timeout(timeout),
    .busAddr(busAddr), .busMreq(busMreq), .busRd(busRd), .busMsyn(busMsyn),
    .busData(busData), .busSsyn(busSsyn)
  );

  always #2.5 clk = ~clk;

  // reactive slave: answers master-sync after slaveDelay falling edges
  initial begin
    forever begin
      @(negedge clk);
      if (busMsyn && !slaveMute) begin
        repeat (slaveDelay) @(negedge clk);
        busData = busAddr ^ MAGIC;
        busSsyn = 1'b1;
        while (busMsyn) @(negedge clk);
        repeat (relDelay) @(negedge clk);
        busSsyn = 1'b0;
        busData = '0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    summary();
  end

  // pulse start for one clock; returns on the falling edge after acceptance
  task automatic pulseStart(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    start = 1'b1;
    addr  = a;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(output int cyc);
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // count falling edges with busMsyn high, ending when it drops
  task automatic syncWidth(output int w);
    w = 0;
    while (!busMsyn) @(negedge clk);
    while (busMsyn) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busAddr == '0, "R1 busAddr", 32'(busAddr), 0);
    check(!busMreq && !busRd && !busMsyn, "R1 strobes",
          {29'd0, busMreq, busRd, busMsyn}, 0);
    check(!busy && !done && !timeout, "R1 flags", {29'd0, busy, done, timeout}, 0);
    check(rdata == '0, "R1 rdata", 32'(rdata), 0);
  endtask

  task automatic testBasic();
    int gap;
    int cyc;
    bit moved;
    slaveMute = 0; slaveDelay = 2; relDelay = 3; tmoLimit = 12'd200;
    pulseStart(16'h1234);
    check(busy, "R2 busy after start", 32'(busy), 1);
    gap = 0;
    moved = 0;
    forever begin
      @(negedge clk);
      if (busMsyn) break;
      gap++;
      if (gap == 1) begin
        check(busMreq && busRd, "R2 strobes", {30'd0, busMreq, busRd}, 3);
        check(busAddr == 16'h1234, "R2 busAddr", 32'(busAddr), 32'h1234);
      end
      if (busAddr != 16'h1234) moved = 1;
    end
    check(gap == SETUP_CYC, "R3 setup gap", 32'(gap), 32'(SETUP_CYC));
    while (busMsyn) begin
      if (busAddr != 16'h1234 || !busMreq) moved = 1;
      @(negedge clk);
    end
    check(!moved, "R3 address held", 32'(moved), 0);
    waitDone(cyc);
    check(done, "R4 done seen", 32'(done), 1);
    check(rdata == (16'h1234 ^ MAGIC), "R4 rdata", 32'(rdata), 32'(16'h1234 ^ MAGIC));
    check(!timeout, "R4 no timeout", 32'(timeout), 0);
    check(busAddr == '0 && !busMreq && !busRd && !busMsyn, "R5 released at done",
          {busAddr, 13'd0, busMreq, busRd, busMsyn}, 0);
    check(!busy, "R6 busy low with done", 32'(busy), 0);
    @(negedge clk);
    check(!done, "R6 done one cycle", 32'(done), 0);
  endtask

  task automatic testHold();
    int cyc;
    slaveMute = 0; slaveDelay = 3; relDelay = 15; tmoLimit = 12'd200;
    pulseStart(16'h0F0F);
    while (!busMsyn) @(negedge clk);
    while (busMsyn) @(negedge clk);
    repeat (5) @(negedge clk);
    check(busSsyn, "R6 slave still high", 32'(busSsyn), 1);
    check(busy && !done, "R6 waits for slave", {30'd0, busy, done}, 2);
    check(busAddr == '0 && !busMreq && !busRd, "R5 negated after ack",
          {busAddr, 14'd0, busMreq, busRd}, 0);
    waitDone(cyc);
    check(done && rdata == (16'h0F0F ^ MAGIC), "R4 hold rdata", 32'(rdata),
          32'(16'h0F0F ^ MAGIC));
    @(negedge clk);
  endtask

  task automatic testSlow();
    int cyc;
    slaveMute = 0; slaveDelay = 150; relDelay = 2; tmoLimit = 12'd200;
    pulseStart(16'hBEEF);
    waitDone(cyc);
    check(done && !timeout, "R8 slow completes", {30'd0, done, timeout}, 2);
    check(rdata == (16'hBEEF ^ MAGIC), "R8 slow rdata", 32'(rdata), 32'(16'hBEEF ^ MAGIC));
    @(negedge clk);
  endtask

  task automatic testIgnore();
    int dones;
    bit moved;
    slaveMute = 0; slaveDelay = 6; relDelay = 4; tmoLimit = 12'd200;
    pulseStart(16'h2222);
    dones = 0;
    moved = 0;
    repeat (3) @(negedge clk);
    start = 1'b1;
    addr  = 16'h3333;
    @(negedge clk);
    start = 1'b0;
    repeat (80) begin
      if (done) dones++;
      if (busAddr == 16'h3333) moved = 1;
      @(negedge clk);
    end
    check(dones == 1, "R7 single done", 32'(dones), 1);
    check(!moved, "R7 address untouched", 32'(moved), 0);
    check(rdata == (16'h2222 ^ MAGIC), "R7 rdata first addr", 32'(rdata),
          32'(16'h2222 ^ MAGIC));
    check(!busy && !busMreq, "R7 no second cycle", {30'd0, busy, busMreq}, 0);
  endtask

  task automatic testTimeout();
    int w;
    int cyc;
    logic [DATA_W-1:0] prev;
    slaveMute = 1; tmoLimit = 12'd12;
    prev = rdata;
    pulseStart(16'h4444);
    syncWidth(w);
    check(w == 12, "R9 sync width", 32'(w), 12);
    check(!busMreq && !busRd && busAddr == '0, "R9 strobes dropped",
          {busAddr, 14'd0, busMreq, busRd}, 0);
    waitDone(cyc);
    check(done && timeout, "R9 done with timeout", {30'd0, done, timeout}, 3);
    check(rdata == prev, "R9 rdata kept", 32'(rdata), 32'(prev));
    repeat (3) @(negedge clk);
    check(timeout, "R11 timeout sticky", 32'(timeout), 1);
  endtask

  task automatic testClear();
    int cyc;
    slaveMute = 0; slaveDelay = 2; relDelay = 2; tmoLimit = 12'd200;
    pulseStart(16'h5555);
    check(!timeout, "R11 cleared on start", 32'(timeout), 0);
    waitDone(cyc);
    @(negedge clk);
  endtask

  task automatic testRace();
    int w;
    int cyc;
    logic [DATA_W-1:0] prev;
    slaveMute = 0; relDelay = 2; tmoLimit = 12'd12;
    slaveDelay = 8;
    pulseStart(16'h6060);
    syncWidth(w);
    waitDone(cyc);
    check(w == 12, "R10 race width", 32'(w), 12);
    check(!timeout, "R10 ack wins", 32'(timeout), 0);
    check(rdata == (16'h6060 ^ MAGIC), "R10 race rdata", 32'(rdata), 32'(16'h6060 ^ MAGIC));
    @(negedge clk);
    prev = rdata;
    slaveDelay = 9;
    pulseStart(16'h7070);
    syncWidth(w);
    waitDone(cyc);
    check(w == 12, "R10 late width", 32'(w), 12);
    check(timeout, "R10 one late times out", 32'(timeout), 1);
    check(rdata == prev, "R10 late rdata kept", 32'(rdata), 32'(prev));
    repeat (10) @(negedge clk);
  endtask

  initial begin
    testReset();
    testBasic();
    testHold();
    testSlow();
    testIgnore();
    testTimeout();
    testClear();
    testRace();
    repeat (5) @(negedge clk);
    summary();
  end

endmodule